// File: doc/BRIEF.md
# Circular-Buffer Next-Address Unit

This block works out the next value of one address pointer for a DSP-style data path. Each cycle it takes a current pointer, a signed step register, a modifier word and a step command. From these it produces the updated pointer one clock later. The modifier word selects the arithmetic. All ones gives plain two's-complement stepping. Zero passes through a bit-reversed result that an outside reverse-carry adder supplies. Any other value makes the pointer move around a circular buffer whose length is the modifier plus one.

In the circular case an absolute adder forms pointer plus step, and a second adder moves that sum back by one buffer length in the opposite direction. The block does not compare against buffer bounds. It finds the top set bit of the modifier and looks at the carries out of that bit position in both adders. The direction of the step then decides which carry test drives the wrap select. A buffer of length L must start at a multiple of 2^k, where 2^k is the smallest power of two not below L. If a circular-mode step is larger than the buffer length, the block raises an error flag.

The block has no state machine. It is a combinational datapath feeding one output register stage, cleared by an asynchronous active-low reset.

Top module: `modaddr_alu`

## Requirements
- R1: While reset is held, `addr_out` and `range_err` are 0.
- R2: Each result appears on the outputs on the first rising clock edge after the inputs that produce it.
- R3: With `modifier_in` = 0xFFFF the pointer steps linearly modulo 2^16. The `step_in` codes are 0 hold, 1 plus one, 2 minus one, 3 plus `offset_in`, 4 minus `offset_in`, and 5 to 7 also hold. So 0x7706 plus 5 gives 0x770B, 0x5678 minus 6 gives 0x5672, and 0xFFFF plus one gives 0x0000.
- R4: With `modifier_in` = 0 the output equals `bitrev_in`, whatever the step command.
- R5: Any other modifier value M defines a buffer of length M+1 starting at base B, a multiple of 2^k with 2^k ≥ M+1. For a pointer inside it and a step s with |s| ≤ M+1, the result is B + ((pointer − B + s) mod (M+1)).
- R6: A forward step that passes the top entry B+M wraps to the low end. For M=19, B=64, 80 plus 5 gives 65.
- R7: A backward step that passes below B wraps to the high end. For M=19, B=64, 66 minus 5 gives 81. With B=0, 2 minus 5 gives 17.
- R8: A step that lands exactly on B or on B+M does not wrap, and a step of exactly ±(M+1) returns the starting pointer.
- R9: When the buffer length is a power of two the wrap still works, including a buffer at the top of the address space. For M=63, B=0xFFC0, 0xFFFF plus one gives 0xFFC0.
- R10: `range_err` is 1 exactly when the modifier selects circular arithmetic and the step magnitude exceeds M+1. It is never set in linear or bit-reverse mode.
- R11: In circular mode, a negative `offset_in` with command 3 is a backward step (its sign bit selects the lower-bound test).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 16 | Current pointer value |
| offset_in | input | 16 | Signed step register |
| modifier_in | input | 16 | Arithmetic select / buffer length minus one |
| bitrev_in | input | 16 | Result of the external reverse-carry adder |
| step_in | input | 3 | Step command code |
| addr_out | output | 16 | Registered next pointer |
| range_err | output | 1 | Registered step-too-large flag |

## Verification
The circular-mode assertions assume the incoming pointer already lies inside a correctly aligned buffer. Given that, the result must keep the bits above the modifier's top set bit and must not run past B+M. The bench respects this in its circular tests: every start value is drawn from inside a buffer at an aligned base, and step sizes stay at or below the buffer length. The one exception is the error test, which checks only the flag. Linear and bit-reverse tests place no constraint on the pointer.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

    typedef enum logic [2:0] {
        STEP_HOLD = 3'd0,
        STEP_INC  = 3'd1,
        STEP_DEC  = 3'd2,
        STEP_ADDN = 3'd3,
        STEP_SUBN = 3'd4
    } step_e;

    typedef enum logic [1:0] {
        ARITH_LINEAR  = 2'd0,
        ARITH_MODULO  = 2'd1,
        ARITH_REVERSE = 2'd2
    } arith_e;

endpackage

// File: rtl/modaddr_adder.sv
module modaddr_adder #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          cin,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] cout
);

    logic [AW:0] c;
    assign c[0] = cin;

    genvar i;
    generate
        for (i = 0; i < AW; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ c[i];
            assign c[i+1]  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
            assign cout[i] = c[i+1];
        end
    endgenerate

endmodule

// File: rtl/modaddr_wrap.sv
module modaddr_wrap #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] modifier,
    input  logic [AW-1:0] carry_abs,
    input  logic [AW-1:0] carry_mod,
    input  logic          backward,
    output logic          wrap,
    output logic [AW-1:0] blk_mask
);

    logic [AW-1:0] top_bit;
    logic          sel_abs;
    logic          sel_mod;
    logic          up_cross;
    logic          down_cross;

    // priority encoder: one-hot position of the highest set modifier bit
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < AW; i++) begin
            if (modifier[i]) begin
                top_bit    = '0;
                top_bit[i] = 1'b1;
            end
        end
    end

    // mask of all bits at or below that position
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = AW - 1; i >= 0; i--) begin
            seen        = seen | top_bit[i];
            blk_mask[i] = seen;
        end
    end

    assign sel_abs    = |(carry_abs & top_bit);
    assign sel_mod    = |(carry_mod & top_bit);
    assign up_cross   = sel_abs | sel_mod;
    assign down_cross = ~sel_abs;
    assign wrap       = backward ? down_cross : up_cross;

    // R5
    enc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(top_bit) && ((modifier == '0) == (top_bit == '0)));

endmodule

// File: rtl/modaddr_alu.sv
module modaddr_alu
    import modaddr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] offset_in,
    input  logic [AW-1:0] modifier_in,
    input  logic [AW-1:0] bitrev_in,
    input  logic [2:0]    step_in,
    output logic [AW-1:0] addr_out,
    output logic          range_err
);

    localparam logic [AW-1:0] ONE     = AW'(1);
    localparam logic [AW-1:0] ALLONES = '1;

    step_e         step;
    arith_e        arith;
    logic [AW-1:0] delta;
    logic          backward;
    logic [AW-1:0] abs_sum, abs_carry;
    logic [AW-1:0] mod_b;
    logic [AW-1:0] wrap_sum, wrap_carry;
    logic          wrap;
    logic [AW-1:0] blk_mask;
    logic [AW-1:0] magnitude;
    logic          err_next;
    logic [AW-1:0] addr_next;

    assign step = step_e'(step_in);

    // step decode
    always_comb begin
        case (step)
            STEP_INC:  delta = ONE;
            STEP_DEC:  delta = ALLONES;
            STEP_ADDN: delta = offset_in;
            STEP_SUBN: delta = ~offset_in + ONE;
            default:   delta = '0;
        endcase
    end

    assign backward = delta[AW-1];

    // modifier decode
    always_comb begin
        if (modifier_in == ALLONES)
            arith = ARITH_LINEAR;
        else if (modifier_in == '0)
            arith = ARITH_REVERSE;
        else
            arith = ARITH_MODULO;
    end

    modaddr_adder #(.AW(AW)) u_abs (
        .a    (addr_in),
        .b    (delta),
        .cin  (1'b0),
        .sum  (abs_sum),
        .cout (abs_carry)
    );

    // forward: subtract length (add ~M); backward: add length (M + 1)
    assign mod_b = backward ? modifier_in : ~modifier_in;

    modaddr_adder #(.AW(AW)) u_mod (
        .a    (abs_sum),
        .b    (mod_b),
        .cin  (backward),
        .sum  (wrap_sum),
        .cout (wrap_carry)
    );

    modaddr_wrap #(.AW(AW)) u_wrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .modifier  (modifier_in),
        .carry_abs (abs_carry),
        .carry_mod (wrap_carry),
        .backward  (backward),
        .wrap      (wrap),
        .blk_mask  (blk_mask)
    );

    assign magnitude = backward ? (~delta + ONE) : delta;
    assign err_next  = (arith == ARITH_MODULO) &&
                       ({1'b0, magnitude} > ({1'b0, modifier_in} + (AW+1)'(1)));

    // result select
    always_comb begin
        unique case (arith)
            ARITH_LINEAR:  addr_next = abs_sum;
            ARITH_REVERSE: addr_next = bitrev_in;
            ARITH_MODULO:  addr_next = wrap ? wrap_sum : abs_sum;
            default:       addr_next = abs_sum;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_out  <= '0;
            range_err <= 1'b0;
        end else begin
            addr_out  <= addr_next;
            range_err <= err_next;
        end
    end

    // R3
    linear_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modifier_in == ALLONES && step_in == 3'd1) |=> addr_out == $past(addr_in) + ONE);

    // R4
    reverse_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modifier_in == '0) |=> addr_out == $past(bitrev_in));

    // R5
    mod_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arith == ARITH_MODULO && !err_next && ((addr_in & blk_mask) <= modifier_in))
        |=> ((addr_out & ~$past(blk_mask)) == ($past(addr_in) & ~$past(blk_mask)))
            && ((addr_out & $past(blk_mask)) <= $past(modifier_in)));

    // R10
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> ($past(modifier_in) != ALLONES && $past(modifier_in) != '0));

endmodule

// File: tb/modaddr_alu_test.sv
`timescale 1ns/1ps
module modaddr_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_in = 16'h1234;
    logic [15:0] offset_in = 16'h0003;
    logic [15:0] modifier_in = 16'hFFFF;
    logic [15:0] bitrev_in = 16'h0000;
    logic [2:0]  step_in = 3'd1;
    logic [15:0] addr_out;
    logic        range_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    modaddr_alu uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_in     (addr_in),
        .offset_in   (offset_in),
        .modifier_in (modifier_in),
        .bitrev_in   (bitrev_in),
        .step_in     (step_in),
        .addr_out    (addr_out),
        .range_err   (range_err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] r, input logic [15:0] n, input logic [15:0] m,
                         input logic [2:0] s);
        addr_in     = r;
        offset_in   = n;
        modifier_in = m;
        step_in     = s;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] circ(input int base, input int len, input int rel, input int off);
        int x;
        x = (rel + off) % len;
        if (x < 0) x = x + len;
        return 16'(base + x);
    endfunction

    task automatic t_reset();
        @(posedge clk); #1;
        check("R1 addr during reset", addr_out, 16'h0000);
        check("R1 err during reset", {15'd0, range_err}, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_linear();
        apply(16'h7706, 16'h0005, 16'hFFFF, 3'd3); check("R3 add N", addr_out, 16'h770B);
        apply(16'h5678, 16'h0006, 16'hFFFF, 3'd4); check("R3 sub N", addr_out, 16'h5672);
        apply(16'h3002, 16'h0004, 16'hFFFF, 3'd4); check("R3 sub N borrow", addr_out, 16'h2FFE);
        apply(16'hFFFF, 16'h0000, 16'hFFFF, 3'd1); check("R3 inc rollover", addr_out, 16'h0000);
        apply(16'h0000, 16'h0000, 16'hFFFF, 3'd2); check("R3 dec rollover", addr_out, 16'hFFFF);
        apply(16'h4735, 16'h0009, 16'hFFFF, 3'd0); check("R3 hold", addr_out, 16'h4735);
        apply(16'h4735, 16'h0009, 16'hFFFF, 3'd6); check("R3 spare code holds", addr_out, 16'h4735);
        // R2: output tracks each new input one edge later
        addr_in = 16'h1000; offset_in = 16'h0; modifier_in = 16'hFFFF; step_in = 3'd1;
        @(posedge clk); #1;
        check("R2 first edge", addr_out, 16'h1001);
        addr_in = 16'h2000;
        #2;
        check("R2 stable between edges", addr_out, 16'h1001);
        @(posedge clk); #1;
        check("R2 next edge", addr_out, 16'h2001);
    endtask

    task automatic t_reverse();
        bitrev_in = 16'h0048;
        apply(16'h0040, 16'h0008, 16'h0000, 3'd3); check("R4 bitrev pass", addr_out, 16'h0048);
        bitrev_in = 16'hA5C3;
        apply(16'h0040, 16'h0008, 16'h0000, 3'd2); check("R4 bitrev any step", addr_out, 16'hA5C3);
        check("R10 no err in reverse", {15'd0, range_err}, 16'h0000);
    endtask

    task automatic t_mod_sweep();
        for (int len = 2; len <= 64; len++) begin
            int base;
            int fwd;
            base = 16'h1200;
            fwd  = len / 3 + 1;
            for (int r = 0; r < len; r++) begin
                apply(16'(base + r), 16'h0, 16'(len - 1), 3'd1);
                check("R5 sweep inc", addr_out, circ(base, len, r, 1));
                apply(16'(base + r), 16'h0, 16'(len - 1), 3'd2);
                check("R5 sweep dec", addr_out, circ(base, len, r, -1));
                apply(16'(base + r), 16'(fwd), 16'(len - 1), 3'd3);
                check("R5 sweep add N", addr_out, circ(base, len, r, fwd));
                apply(16'(base + r), 16'(-fwd), 16'(len - 1), 3'd3);
                check("R11 sweep negative N", addr_out, circ(base, len, r, -fwd));
                apply(16'(base + r), 16'(len), 16'(len - 1), 3'd4);
                check("R8 sweep full-length step", addr_out, 16'(base + r));
            end
        end
    endtask

    task automatic t_mod_edges();
        apply(16'd80, 16'd5, 16'd19, 3'd3);  check("R6 forward wrap", addr_out, 16'd65);
        apply(16'd83, 16'd0, 16'd19, 3'd1);  check("R6 inc at top", addr_out, 16'd64);
        apply(16'd66, 16'd5, 16'd19, 3'd4);  check("R7 backward wrap", addr_out, 16'd81);
        apply(16'd64, 16'd0, 16'd19, 3'd2);  check("R7 dec at base", addr_out, 16'd83);
        apply(16'd2,  16'd5, 16'd19, 3'd4);  check("R7 wrap at zero base", addr_out, 16'd17);
        apply(16'd78, 16'd5, 16'd19, 3'd3);  check("R8 land on top", addr_out, 16'd83);
        apply(16'd69, 16'd5, 16'd19, 3'd4);  check("R8 land on base", addr_out, 16'd64);
        apply(16'h004F, 16'd0, 16'd15, 3'd1); check("R9 pow2 wrap", addr_out, 16'h0040);
        apply(16'hFFFF, 16'd0, 16'd63, 3'd1); check("R9 top of space", addr_out, 16'hFFC0);
        apply(16'hFFC0, 16'd0, 16'd63, 3'd2); check("R9 top of space dec", addr_out, 16'hFFFF);
        apply(16'd66, 16'hFFFB, 16'd19, 3'd3); check("R11 negative N wraps", addr_out, 16'd81);
    endtask

    task automatic t_error();
        apply(16'd70, 16'd21, 16'd19, 3'd3);
        check("R10 err forward too big", {15'd0, range_err}, 16'h0001);
        apply(16'd70, 16'd20, 16'd19, 3'd3);
        check("R10 no err at length", {15'd0, range_err}, 16'h0000);
        apply(16'd70, 16'd21, 16'd19, 3'd4);
        check("R10 err backward too big", {15'd0, range_err}, 16'h0001);
        apply(16'd70, 16'hFFEA, 16'd19, 3'd3);
        check("R10 err negative N too big", {15'd0, range_err}, 16'h0001);
        apply(16'd70, 16'h0100, 16'hFFFF, 3'd3);
        check("R10 no err linear", {15'd0, range_err}, 16'h0000);
        apply(16'd70, 16'd3, 16'd19, 3'd3);
        check("R10 err clears", {15'd0, range_err}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_linear();
        t_reverse();
        t_mod_edges();
        t_error();
        t_mod_sweep();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule